// File: doc/BRIEF.md
# SD Card Command Line Engine

This block runs the single-bit command line of an SD card in native bus mode. The host side loads a 6-bit command index and a response-length select, then writes a 32-bit argument. That argument write launches the command. The engine builds a 48-bit token from the index and the argument, adds framing and a CRC7, and shifts the token out one bit per SD clock tick. It then releases the line and listens for the card's reply.

The card may answer after a variable delay. The engine searches for the reply's start bit within a programmable number of ticks. It captures a short (48-bit) or long (136-bit) reply into a response register. It then raises a completion flag, a CRC error flag or a timeout flag.

All protocol progress is gated by an SD clock-enable input supplied from outside, so the engine runs from the fast system clock at any card clock ratio. An abort input abandons an exchange at any point.

Top module: `sd_cmd_engine`

## Requirements
- R1: The transmitted token is 48 bits, sent most significant bit first, one bit per enabled tick. Its fields are: bit 47 start (0), bit 46 direction (1), bits 45:40 index, bits 39:8 argument, bits 7:1 CRC7 (polynomial x^7+x^3+1, initial value 0) over bits 47:8, and bit 0 stop (1). Index 0 with argument 0 gives token 0x400000000095.
- R2: A write of the argument while idle launches a command using the index held at that time. Index and argument writes made while a command is in progress are ignored: they start no second token and do not change the index of the next command.
- R3: Transmission starts only on an enabled tick where the command line reads high. While the line is held low, the engine does not drive it.
- R4: The output enable is high for exactly the 48 enabled ticks of the token and is low at every other time, including the whole listening phase.
- R5: After the stop bit, a reply start bit (0) seen on enabled tick k of the listening phase is accepted when k is at most the timeout limit (limit of 1 or more). If no start bit is seen within the limit, the timeout flag is set and the completion flag stays low.
- R6: With the length select at 0, 48 reply bits (start bit included) are captured into response bits 47:0, and bits 135:48 read 0. With the select at 1, 136 bits are captured into bits 135:0. First-received bits end up most significant.
- R7: The completion flag is set when a full reply has been captured. All three flags clear when the next command is launched, and they otherwise hold.
- R8: For a 48-bit reply, the CRC error flag is set when reply bits 7:1 differ from the CRC7 of reply bits 47:8. A 136-bit reply never sets it.
- R9: Abort while busy returns the engine to idle at the next clock. The line is released, busy drops and no flag is set.
- R10: After reset: output enable 0, busy 0, all flags 0, response register 0.
- R11: State advances only on clock cycles with the SD clock enable high. With the enable high every third cycle, each token bit is held for three cycles and the line is driven for 144 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_ce | input | 1 | SD clock tick enable |
| cmd_idx_we | input | 1 | Write strobe for index and length select |
| cmd_idx | input | 6 | Command index |
| cmd_rsp_long | input | 1 | Reply length select: 0 = 48 bits, 1 = 136 bits |
| cmd_arg_we | input | 1 | Argument write strobe; launches a command |
| cmd_arg | input | 32 | Command argument |
| rsp_timeout | input | TO_W | Start-bit search limit in enabled ticks |
| abort | input | 1 | Abandon the current exchange |
| cmd_i | input | 1 | Command line as seen at the pad |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Command in progress |
| rsp_done | output | 1 | Reply captured (sticky) |
| err_crc | output | 1 | Reply CRC7 mismatch (sticky) |
| err_timeout | output | 1 | No reply start bit in time (sticky) |
| rsp_data | output | 136 | Captured reply, right-aligned |

## Verification
The token builder is exercised across all 64 index values. Each index is paired with a different argument pattern and a different reply delay. This separates field placement faults from CRC faults and from bit-order faults. Crafted replies are used for the other checks. A reply with one CRC bit flipped and a long reply with a meaningless CRC field test the error rule and the length select. Start bits placed on the last allowed tick and one tick later test the timeout boundary. Further runs hold the line low before launch, repeat writes during a transfer, abort partway through the token, and slow the tick enable to one in three cycles. These show that launch gating, write blocking, release and tick gating each act on their own.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
    localparam int IDX_W  = 6;
    localparam int ARG_W  = 32;
    localparam int CRC_W  = 7;
    localparam int TOK_W  = 48;
    localparam int LONG_W = 136;
    localparam int BODY_W = 2 + IDX_W + ARG_W;

    localparam logic [CRC_W-1:0] CRC7_TAPS = 7'h09;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_SEND,
        ST_LISTEN
    } eng_state_t;

    typedef struct packed {
        logic             start;
        logic             dir;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        logic [CRC_W-1:0] crc;
        logic             stop;
    } cmd_token_t;

    // Serial CRC7 over the body, most significant bit first.
    function automatic logic [CRC_W-1:0] crc7_calc(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            fb = body[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC7_TAPS;
        end
        return c;
    endfunction

    function automatic cmd_token_t make_token(input logic [IDX_W-1:0] idx,
                                              input logic [ARG_W-1:0] arg);
        cmd_token_t t;
        t.start = 1'b0;
        t.dir   = 1'b1;
        t.idx   = idx;
        t.arg   = arg;
        t.crc   = crc7_calc({1'b0, 1'b1, idx, arg});
        t.stop  = 1'b1;
        return t;
    endfunction
endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
    import sd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       load,
    input  logic       kill,
    input  cmd_token_t token,
    output logic       line_out,
    output logic       line_oe,
    output logic       fin
);
    localparam int CNT_W = $clog2(TOK_W);

    logic [TOK_W-1:0] sh;
    logic [CNT_W-1:0] cnt;

    assign fin      = ce && line_oe && (cnt == CNT_W'(TOK_W - 1));
    assign line_out = line_oe ? sh[TOK_W-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            line_oe <= 1'b0;
        end else if (kill) begin
            line_oe <= 1'b0;
        end else if (load) begin
            sh      <= token;
            cnt     <= '0;
            line_oe <= 1'b1;
        end else if (ce && line_oe) begin
            sh  <= {sh[TOK_W-2:0], 1'b0};
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(TOK_W - 1)) line_oe <= 1'b0;
        end
    end

    // The first bit on the wire after the driver turns on is the start bit.
    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> (line_out == 1'b0));

    // Between enabled ticks the driven bit does not move.
    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (rst)
        (line_oe && $past(line_oe) && !$past(ce) && !$past(load)) |-> $stable(line_out));
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
    import sd_cmd_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              arm,
    input  logic              kill,
    input  logic              long_sel,
    input  logic [TO_W-1:0]   to_limit,
    input  logic              line_in,
    output logic              active,
    output logic              got_p,
    output logic              to_p,
    output logic              bad_p,
    output logic [LONG_W-1:0] data
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    logic              waiting;
    logic              recving;
    logic [TO_W-1:0]   timer;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  need;
    logic [LONG_W-1:0] sh;
    logic [LONG_W-1:0] sh_n;
    logic [TO_W-1:0]   last_tick;

    assign need      = long_sel ? CNT_W'(LONG_W) : CNT_W'(TOK_W);
    assign sh_n      = {sh[LONG_W-2:0], line_in};
    assign last_tick = to_limit - {{(TO_W-1){1'b0}}, 1'b1};
    assign active    = waiting || recving;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
            recving <= 1'b0;
            timer   <= '0;
            cnt     <= '0;
            sh      <= '0;
            got_p   <= 1'b0;
            to_p    <= 1'b0;
            bad_p   <= 1'b0;
            data    <= '0;
        end else begin
            got_p <= 1'b0;
            to_p  <= 1'b0;
            bad_p <= 1'b0;
            if (kill) begin
                waiting <= 1'b0;
                recving <= 1'b0;
            end else if (arm) begin
                waiting <= 1'b1;
                recving <= 1'b0;
                timer   <= '0;
            end else if (ce && waiting) begin
                if (!line_in) begin
                    waiting <= 1'b0;
                    recving <= 1'b1;
                    sh      <= '0;
                    cnt     <= CNT_W'(1);
                end else if (timer == last_tick) begin
                    waiting <= 1'b0;
                    to_p    <= 1'b1;
                end else begin
                    timer <= timer + TO_W'(1);
                end
            end else if (ce && recving) begin
                sh  <= sh_n;
                cnt <= cnt + CNT_W'(1);
                if (cnt == need - CNT_W'(1)) begin
                    recving <= 1'b0;
                    got_p   <= 1'b1;
                    if (long_sel) begin
                        data  <= sh_n;
                        bad_p <= 1'b0;
                    end else begin
                        data  <= {{(LONG_W-TOK_W){1'b0}}, sh_n[TOK_W-1:0]};
                        bad_p <= (crc7_calc(sh_n[TOK_W-1:CRC_W+1]) != sh_n[CRC_W:1]);
                    end
                end
            end
        end
    end

    // A listening phase ends in exactly one way.
    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        !(got_p && to_p));

    // A CRC verdict only accompanies a completed reply.
    assert_crc_with_reply_R8: assert property (@(posedge clk) disable iff (rst)
        bad_p |-> got_p);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sd_ce,
    input  logic              cmd_idx_we,
    input  logic [5:0]        cmd_idx,
    input  logic              cmd_rsp_long,
    input  logic              cmd_arg_we,
    input  logic [31:0]       cmd_arg,
    input  logic [TO_W-1:0]   rsp_timeout,
    input  logic              abort,
    input  logic              cmd_i,
    output logic              cmd_o,
    output logic              cmd_oe,
    output logic              busy,
    output logic              rsp_done,
    output logic              err_crc,
    output logic              err_timeout,
    output logic [135:0]      rsp_data
);
    eng_state_t        state;
    logic [IDX_W-1:0]  idx_q;
    logic [ARG_W-1:0]  arg_q;
    logic              long_q;
    cmd_token_t        token;
    logic              tx_load, tx_fin, tx_oe, tx_line;
    logic              rx_arm, rx_active, rx_got, rx_to, rx_bad;
    logic [LONG_W-1:0] rx_data;

    assign token   = make_token(idx_q, arg_q);
    assign tx_load = (state == ST_PEND) && sd_ce && cmd_i && !abort;
    assign rx_arm  = tx_fin && !abort;
    assign busy    = (state != ST_IDLE);
    assign cmd_o   = tx_line;
    assign cmd_oe  = tx_oe;

    sd_cmd_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .ce       (sd_ce),
        .load     (tx_load),
        .kill     (abort),
        .token    (token),
        .line_out (tx_line),
        .line_oe  (tx_oe),
        .fin      (tx_fin)
    );

    sd_cmd_rx #(.TO_W(TO_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ce       (sd_ce),
        .arm      (rx_arm),
        .kill     (abort),
        .long_sel (long_q),
        .to_limit (rsp_timeout),
        .line_in  (cmd_i),
        .active   (rx_active),
        .got_p    (rx_got),
        .to_p     (rx_to),
        .bad_p    (rx_bad),
        .data     (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx_q       <= '0;
            arg_q       <= '0;
            long_q      <= 1'b0;
            rsp_done    <= 1'b0;
            err_crc     <= 1'b0;
            err_timeout <= 1'b0;
            rsp_data    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_idx_we) begin
                        idx_q  <= cmd_idx;
                        long_q <= cmd_rsp_long;
                    end
                    if (cmd_arg_we) begin
                        arg_q       <= cmd_arg;
                        state       <= ST_PEND;
                        rsp_done    <= 1'b0;
                        err_crc     <= 1'b0;
                        err_timeout <= 1'b0;
                    end
                end
                ST_PEND: begin
                    if (abort)        state <= ST_IDLE;
                    else if (tx_load) state <= ST_SEND;
                end
                ST_SEND: begin
                    if (abort)       state <= ST_IDLE;
                    else if (tx_fin) state <= ST_LISTEN;
                end
                ST_LISTEN: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (rx_got) begin
                        rsp_done <= 1'b1;
                        err_crc  <= rx_bad;
                        rsp_data <= rx_data;
                        state    <= ST_IDLE;
                    end else if (rx_to) begin
                        err_timeout <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_launch_on_idle_line_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> $past(cmd_i));

    assert_quiet_while_listening_R4: assert property (@(posedge clk) disable iff (rst)
        rx_active |-> !cmd_oe);

    assert_flags_clear_on_launch_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!rsp_done && !err_crc && !err_timeout));

    assert_abort_releases_R9: assert property (@(posedge clk) disable iff (rst)
        (abort && busy) |=> (!busy && !cmd_oe));

    assert_drive_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> busy);
endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sd_ce;
    logic         cmd_idx_we = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic         cmd_rsp_long = 1'b0;
    logic         cmd_arg_we = 1'b0;
    logic [31:0]  cmd_arg = '0;
    logic [15:0]  rsp_timeout = 16'd16;
    logic         abort = 1'b0;
    logic         cmd_i;
    logic         cmd_o, cmd_oe, busy, rsp_done, err_crc, err_timeout;
    logic [135:0] rsp_data;
    logic         card_drv = 1'b1;

    int checks = 0;
    int fails  = 0;
    int ce_div = 1;
    int ce_cnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) ce_cnt <= (ce_cnt + 1 >= ce_div) ? 0 : ce_cnt + 1;
    assign sd_ce = (ce_cnt == 0);
    assign cmd_i = cmd_oe ? cmd_o : card_drv;

    sd_cmd_engine u_sd_cmd_engine (
        .clk(clk), .rst(rst), .sd_ce(sd_ce),
        .cmd_idx_we(cmd_idx_we), .cmd_idx(cmd_idx), .cmd_rsp_long(cmd_rsp_long),
        .cmd_arg_we(cmd_arg_we), .cmd_arg(cmd_arg), .rsp_timeout(rsp_timeout),
        .abort(abort), .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
        .busy(busy), .rsp_done(rsp_done), .err_crc(err_crc),
        .err_timeout(err_timeout), .rsp_data(rsp_data)
    );

    // Remainder of polynomial division by 0x89 over the 40-bit body.
    function automatic logic [6:0] ref_crc(input logic [39:0] b);
        logic [46:0] v;
        v = {b, 7'b0};
        for (int k = 46; k >= 7; k--)
            if (v[k]) v = v ^ (47'h89 << (k - 7));
        return v[6:0];
    endfunction

    function automatic logic [47:0] exp_token(input logic [5:0] i, input logic [31:0] a);
        return {2'b01, i, a, ref_crc({2'b01, i, a}), 1'b1};
    endfunction

    function automatic logic [47:0] card_short(input logic [5:0] i, input logic [31:0] s);
        return {2'b00, i, s, ref_crc({2'b00, i, s}), 1'b1};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic ce_tick();
        do @(negedge clk); while (!sd_ce);
    endtask

    task automatic launch(input bit wr_idx, input logic [5:0] i, input bit lng,
                          input logic [31:0] a);
        @(negedge clk);
        if (wr_idx) begin
            cmd_idx_we   = 1'b1;
            cmd_idx      = i;
            cmd_rsp_long = lng;
        end
        cmd_arg_we = 1'b1;
        cmd_arg    = a;
        @(negedge clk);
        cmd_idx_we = 1'b0;
        cmd_arg_we = 1'b0;
    endtask

    // Collects bits the card would sample; optional write poke or abort at bit n.
    task automatic capture(input int poke_at, input int abort_at,
                           output logic [47:0] tok, output int oe_cycles);
        int n = 0;
        tok = '0;
        oe_cycles = 0;
        for (int g = 0; g < 20000; g++) begin
            if (cmd_oe) oe_cycles++;
            if (sd_ce && cmd_oe) begin
                tok = {tok[46:0], cmd_o};
                n++;
            end
            if (n == 48) break;
            if (n == abort_at) begin
                abort = 1'b1;
                break;
            end
            @(negedge clk);
            cmd_idx_we = 1'b0;
            cmd_arg_we = 1'b0;
            if (n == poke_at) begin
                cmd_idx_we = 1'b1;
                cmd_idx    = 6'd63;
                cmd_arg_we = 1'b1;
                cmd_arg    = 32'hDEAD_BEEF;
            end
        end
    endtask

    task automatic card_reply(input int delay, input logic [135:0] bits, input int n);
        for (int d = 0; d < delay; d++) begin
            ce_tick();
            card_drv = 1'b1;
        end
        for (int k = n - 1; k >= 0; k--) begin
            ce_tick();
            card_drv = bits[k];
        end
        ce_tick();
        card_drv = 1'b1;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0]  tok;
        logic [47:0]  rsp;
        logic [135:0] lrsp;
        int           oe_n;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "oe after reset", cmd_oe, 0);
        chk("R10", "busy after reset", busy, 0);
        chk("R10", "flags after reset", {rsp_done, err_crc, err_timeout}, 0);
        chk("R10", "rsp after reset", rsp_data, 0);

        // R1 known constant token
        launch(1, 6'd0, 0, 32'd0);
        capture(-1, -1, tok, oe_n);
        chk("R1", "index0 token constant", tok, 48'h4000_0000_0095);
        chk("R4", "oe cycle count", oe_n, 48);
        rsp = card_short(6'd0, 32'h0000_0120);
        card_reply(2, rsp, 48);
        wait_idle();
        chk("R7", "done after short reply", rsp_done, 1);
        chk("R8", "no crc error", err_crc, 0);
        chk("R6", "short reply data", rsp_data, {88'b0, rsp});

        // R1 R6 sweep over every index with varied arguments and delays
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            logic [31:0] s;
            a = (32'(i) * 32'h9E37_79B9) ^ (32'h1 << (i % 32));
            s = ~a ^ 32'(i);
            launch(1, 6'(i), 0, a);
            capture(-1, -1, tok, oe_n);
            chk("R1", "sweep token", tok, exp_token(6'(i), a));
            rsp = card_short(6'(i), s);
            card_reply(i % 5, rsp, 48);
            wait_idle();
            chk("R7", "sweep done", rsp_done, 1);
            chk("R8", "sweep crc ok", err_crc, 0);
            chk("R6", "sweep data", rsp_data, {88'b0, rsp});
            chk("R4", "sweep released", cmd_oe, 0);
        end

        // R8 corrupted CRC bit
        launch(1, 6'd13, 0, 32'h0000_0400);
        capture(-1, -1, tok, oe_n);
        rsp = card_short(6'd13, 32'h0000_0900) ^ 48'h8;
        card_reply(1, rsp, 48);
        wait_idle();
        chk("R8", "bad crc flagged", err_crc, 1);
        chk("R7", "done with bad crc", rsp_done, 1);

        // R6 R8 long reply with meaningless CRC field
        launch(1, 6'd2, 1, 32'h0);
        capture(-1, -1, tok, oe_n);
        lrsp = {8'h3F, 120'hA5_0123_4567_89AB_CDEF_F0E1_D2C3_B4A5, 8'h55};
        card_reply(3, lrsp, 136);
        wait_idle();
        chk("R6", "long reply data", rsp_data, lrsp);
        chk("R8", "long reply no crc err", err_crc, 0);
        chk("R7", "long reply done", rsp_done, 1);

        // R5 timeout boundary
        rsp_timeout = 16'd5;
        launch(1, 6'd8, 0, 32'h1AA);
        capture(-1, -1, tok, oe_n);
        rsp = card_short(6'd8, 32'h1AA);
        card_reply(4, rsp, 48);
        wait_idle();
        chk("R5", "start bit on last tick accepted", {rsp_done, err_timeout}, 2'b10);
        launch(1, 6'd8, 0, 32'h1AA);
        capture(-1, -1, tok, oe_n);
        card_reply(5, rsp, 48);
        wait_idle();
        chk("R5", "late start bit times out", {rsp_done, err_timeout}, 2'b01);
        chk("R7", "flags cleared by new launch", err_crc, 0);
        rsp_timeout = 16'd16;
        repeat (60) @(negedge clk);

        // R3 line held low before launch
        card_drv = 1'b0;
        launch(1, 6'd17, 0, 32'h0000_0200);
        begin
            int seen = 0;
            for (int t = 0; t < 10; t++) begin
                ce_tick();
                if (cmd_oe) seen++;
            end
            chk("R3", "no drive while line low", seen, 0);
        end
        card_drv = 1'b1;
        capture(-1, -1, tok, oe_n);
        chk("R3", "token after line release", tok, exp_token(6'd17, 32'h200));
        card_reply(0, card_short(6'd17, 32'h0), 48);
        wait_idle();

        // R2 writes during a transfer are ignored
        launch(1, 6'd12, 0, 32'h5555_0000);
        capture(20, -1, tok, oe_n);
        chk("R2", "token unaffected by busy write", tok, exp_token(6'd12, 32'h5555_0000));
        rsp = card_short(6'd12, 32'h7);
        card_reply(1, rsp, 48);
        wait_idle();
        chk("R2", "reply after busy write", rsp_data, {88'b0, rsp});
        begin
            int extra = 0;
            for (int t = 0; t < 150; t++) begin
                @(negedge clk);
                if (cmd_oe || busy) extra++;
            end
            chk("R2", "no second command", extra, 0);
        end
        launch(0, 6'd0, 0, 32'h0000_0F0F);
        capture(-1, -1, tok, oe_n);
        chk("R2", "index unchanged by busy write", tok, exp_token(6'd12, 32'h0F0F));
        card_reply(0, card_short(6'd12, 32'h0), 48);
        wait_idle();

        // R9 abort during the token
        launch(1, 6'd24, 0, 32'hCAFE_0000);
        capture(-1, 10, tok, oe_n);
        @(negedge clk);
        abort = 1'b0;
        chk("R9", "line released on abort", cmd_oe, 0);
        chk("R9", "busy cleared on abort", busy, 0);
        chk("R9", "no flags on abort", {rsp_done, err_crc, err_timeout}, 0);

        // R11 divided tick enable
        ce_div = 3;
        repeat (6) @(negedge clk);
        launch(1, 6'd55, 0, 32'h8000_0001);
        capture(-1, -1, tok, oe_n);
        chk("R11", "token with divided ticks", tok, exp_token(6'd55, 32'h8000_0001));
        chk("R11", "drive cycles with divided ticks", oe_n, 144);
        rsp = card_short(6'd55, 32'h00FF_00FF);
        card_reply(2, rsp, 48);
        wait_idle();
        chk("R11", "reply with divided ticks", rsp_data, {88'b0, rsp});
        ce_div = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule